// File: doc/BRIEF.md
# Low-Speed Periodic Wake Timer

This block raises a periodic wake request from a free-running low-speed clock of about 128 kHz. That clock keeps running while the rest of the chip is powered down. Three configuration fields sit in the system clock domain and are written through a small register-style write port:

- an enable bit;
- a 4-bit prescaler code;
- a 6-bit window value.

The fields are carried into the low-speed domain by two-stage synchronisers. The prescaler code chooses how many low-speed cycles make up one counting tick. Its encoding is not a plain power of two:

- two codes give no division;
- the middle codes double the division at each step;
- the two top codes give the long ratios 10240 and 61440.

A 6-bit counter advances once per tick. On a tick while the counter already holds the window value, the counter wraps to zero and the block emits a one-cycle wake pulse. Consecutive wake pulses are therefore (window+1) ticks apart.

The control is a three-state machine clocked by the low-speed clock:

- `AWU_OFF`: counters held at zero.
- `AWU_COUNT`: counting, no pulse.
- `AWU_FIRE`: the single cycle that drives the wake output.

Its transitions are:

- OFF→COUNT when the synchronised enable is 1.
- COUNT→FIRE on a tick whose counter equals the window (a hit).
- FIRE→FIRE on another hit.
- FIRE→COUNT when no hit occurs.
- COUNT→OFF and FIRE→OFF whenever the synchronised enable reads 0.

Top module: `awu_timer`

## Requirements
- R1: After reset the enable reads 0, the prescaler code reads 0, the window reads 0x3F, and the wake output is 0.
- R2: A write with address 0 sets the enable from data bit 0. Address 1 sets the window from data bits 5:0. Address 2 sets the prescaler code from data bits 3:0. Address 3 changes nothing. Every readback shows the new value one system clock after the write.
- R3: While the enable is 0 the wake output stays 0.
- R4: Prescaler codes 0 and 1 both make every low-speed cycle a tick.
- R5: Prescaler codes 2 to 13 give one tick every 2^(code-1) low-speed cycles.
- R6: Prescaler code 14 gives one tick every 10240 low-speed cycles. Code 15 gives one tick every 61440 low-speed cycles.
- R7: The counter advances once per tick. A tick that finds the counter equal to the window wraps it to 0 and produces a wake pulse. Consecutive wake rises are (window+1)×ratio low-speed cycles apart.
- R8: Each match drives the wake output high for exactly one low-speed cycle. The one exception is window 0 with a ratio of 1, where wake stays high continuously.
- R9: Clearing the enable returns the counter and the prescaler to 0. A later enable waits the full first period again.
- R10: Take the first low-speed rising edge after the enable register turns on as edge 1. The first wake rise follows edge 3+(window+1)×ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| lsi_clk | input | 1 | Low-speed clock that runs the timer |
| wr_valid | input | 1 | Write strobe for the configuration port |
| wr_addr | input | 2 | Field select: 0 enable, 1 window, 2 prescaler |
| wr_data | input | 6 | Write data |
| cfg_en_o | output | 1 | Current enable register |
| cfg_psc_o | output | 4 | Current prescaler code register |
| cfg_win_o | output | 6 | Current window register |
| wake_o | output | 1 | Wake pulse, low-speed clock domain |

## Verification
The timer is run with several prescaler codes and window values:

- Codes 0 and 1 are run with the same window. Their equal pulse spacing separates the two no-division codes from the doubling codes.
- Codes 3 and 6 with non-zero windows check the doubling rule and the (window+1) period.
- Codes 14 and 15 check only the first wake delay, which is enough to catch a wrong long ratio.

Window 0 with no division shows the continuous-high corner. A disable that lands mid-count, followed by a re-enable, shows whether both counters restart. Writes to the unused address show that the register port ignores them.

// File: rtl/awu_pkg.sv
`timescale 1ns/100ps
package awu_pkg;

    localparam int PSC_W   = 4;
    localparam int PCNT_W  = 16;
    localparam int ADDR_W  = 2;
    localparam int RATIO_A = 10240;
    localparam int RATIO_B = 61440;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_WIN  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_PSC  = 2'd2;

    typedef enum logic [1:0] {
        AWU_OFF   = 2'd0,
        AWU_COUNT = 2'd1,
        AWU_FIRE  = 2'd2
    } awu_state_e;

    // Terminal value of the prescale counter (ratio minus one) for a code.
    function automatic logic [PCNT_W-1:0] psc_limit(input logic [PSC_W-1:0] code);
        logic [PCNT_W-1:0] one;
        one = {{(PCNT_W-1){1'b0}}, 1'b1};
        if (code <= 4'd1)
            return '0;
        else if (code == 4'd14)
            return PCNT_W'(RATIO_A - 1);
        else if (code == 4'd15)
            return PCNT_W'(RATIO_B - 1);
        else
            return (one << (code - 4'd1)) - one;
    endfunction

endpackage

// File: rtl/awu_sync.sv
`timescale 1ns/100ps
module awu_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/awu_regs.sv
`timescale 1ns/100ps
module awu_regs
    import awu_pkg::*;
#(
    parameter int WIN_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIN_W-1:0]  wr_data,
    output logic              en_q,
    output logic [PSC_W-1:0]  psc_q,
    output logic [WIN_W-1:0]  win_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            psc_q <= '0;
            win_q <= '1;
        end else if (wr_valid) begin
            if (wr_addr == ADDR_CTRL) en_q  <= wr_data[0];
            if (wr_addr == ADDR_WIN)  win_q <= wr_data;
            if (wr_addr == ADDR_PSC)  psc_q <= wr_data[PSC_W-1:0];
        end
    end

endmodule

// File: rtl/awu_prescaler.sv
`timescale 1ns/100ps
module awu_prescaler
    import awu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PSC_W-1:0]  code,
    output logic              tick,
    output logic [PCNT_W-1:0] pcnt
);

    logic [PCNT_W-1:0] limit;

    always_comb begin
        limit = psc_limit(code);
        tick  = run && (pcnt >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pcnt <= '0;
        else if (!run || tick)   pcnt <= '0;
        else                     pcnt <= pcnt + 1'b1;
    end

endmodule

// File: rtl/awu_fsm.sv
`timescale 1ns/100ps
module awu_fsm
    import awu_pkg::*;
#(
    parameter int WIN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_s,
    input  logic             tick,
    input  logic [WIN_W-1:0] win,
    output logic             run,
    output logic [WIN_W-1:0] cnt,
    output logic             wake
);

    awu_state_e       state_q, state_d;
    logic [WIN_W-1:0] cnt_d;
    logic             hit;

    assign hit = tick && (cnt == win);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AWU_OFF:   if (en_s) state_d = AWU_COUNT;
            AWU_COUNT: begin
                if (!en_s)    state_d = AWU_OFF;
                else if (hit) state_d = AWU_FIRE;
            end
            AWU_FIRE: begin
                if (!en_s)    state_d = AWU_OFF;
                else if (hit) state_d = AWU_FIRE;
                else          state_d = AWU_COUNT;
            end
            default:          state_d = AWU_OFF;
        endcase
    end

    // state and counter registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AWU_OFF;
            cnt     <= '0;
        end else begin
            state_q <= state_d;
            cnt     <= cnt_d;
        end
    end

    always_comb begin
        if (!run)      cnt_d = '0;
        else if (hit)  cnt_d = '0;
        else if (tick) cnt_d = cnt + 1'b1;
        else           cnt_d = cnt;
    end

    // outputs
    always_comb begin
        run  = (state_q != AWU_OFF) && en_s;
        wake = (state_q == AWU_FIRE);
    end

endmodule

// File: rtl/awu_timer.sv
`timescale 1ns/100ps
module awu_timer
    import awu_pkg::*;
#(
    parameter int WIN_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lsi_clk,
    input  logic              wr_valid,
    input  logic [1:0]        wr_addr,
    input  logic [WIN_W-1:0]  wr_data,
    output logic              cfg_en_o,
    output logic [PSC_W-1:0]  cfg_psc_o,
    output logic [WIN_W-1:0]  cfg_win_o,
    output logic              wake_o
);

    localparam int CFG_W = 1 + PSC_W + WIN_W;
    localparam logic [CFG_W-1:0] CFG_RST = {1'b0, {PSC_W{1'b0}}, {WIN_W{1'b1}}};

    logic              en_q;
    logic [PSC_W-1:0]  psc_q;
    logic [WIN_W-1:0]  win_q;
    logic [CFG_W-1:0]  cfg_a;
    logic [CFG_W-1:0]  cfg_s;
    logic              en_s;
    logic [PSC_W-1:0]  psc_s;
    logic [WIN_W-1:0]  win_s;
    logic              run;
    logic              tick;
    logic [PCNT_W-1:0] pcnt;
    logic [WIN_W-1:0]  cnt;

    awu_regs #(.WIN_W(WIN_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .en_q     (en_q),
        .psc_q    (psc_q),
        .win_q    (win_q)
    );

    assign cfg_a = {en_q, psc_q, win_q};

    awu_sync #(.W(CFG_W), .STAGES(SYNC_STAGES), .RST_VAL(CFG_RST)) u_sync (
        .clk   (lsi_clk),
        .rst_n (rst_n),
        .d     (cfg_a),
        .q     (cfg_s)
    );

    assign en_s  = cfg_s[CFG_W-1];
    assign psc_s = cfg_s[WIN_W +: PSC_W];
    assign win_s = cfg_s[WIN_W-1:0];

    awu_prescaler u_psc (
        .clk   (lsi_clk),
        .rst_n (rst_n),
        .run   (run),
        .code  (psc_s),
        .tick  (tick),
        .pcnt  (pcnt)
    );

    awu_fsm #(.WIN_W(WIN_W)) u_fsm (
        .clk   (lsi_clk),
        .rst_n (rst_n),
        .en_s  (en_s),
        .tick  (tick),
        .win   (win_s),
        .run   (run),
        .cnt   (cnt),
        .wake  (wake_o)
    );

    assign cfg_en_o  = en_q;
    assign cfg_psc_o = psc_q;
    assign cfg_win_o = win_q;

endmodule

// File: rtl/awu_timer_chk.sv
`timescale 1ns/100ps
module awu_timer_chk
    import awu_pkg::*;
#(
    parameter int WIN_W = 6
) (
    input logic              clk,
    input logic              lsi_clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [1:0]        wr_addr,
    input logic [1+PSC_W+WIN_W-1:0] cfg_q,
    input logic              en_s,
    input logic [PSC_W-1:0]  psc_s,
    input logic [WIN_W-1:0]  win_s,
    input logic [PCNT_W-1:0] pcnt,
    input logic [WIN_W-1:0]  cnt,
    input logic              wake
);

    // R9
    clear_on_disable_chk: assert property (@(posedge lsi_clk) disable iff (!rst_n)
        !en_s |=> (pcnt == '0 && cnt == '0));

    // R3
    wake_needs_enable_chk: assert property (@(posedge lsi_clk) disable iff (!rst_n)
        wake |-> $past(en_s));

    // R7
    wrap_on_fire_chk: assert property (@(posedge lsi_clk) disable iff (!rst_n)
        wake |-> (cnt == '0));

    // R8
    single_pulse_chk: assert property (@(posedge lsi_clk) disable iff (!rst_n)
        (wake && $past(wake)) |-> ($past(win_s) == '0 && $past(psc_s) <= 4'd1));

    // R2
    ignore_addr3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr == 2'd3) |=> $stable(cfg_q));

endmodule

bind awu_timer awu_timer_chk #(.WIN_W(WIN_W)) u_chk (
    .clk      (clk),
    .lsi_clk  (lsi_clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .cfg_q    (cfg_a),
    .en_s     (en_s),
    .psc_s    (psc_s),
    .win_s    (win_s),
    .pcnt     (pcnt),
    .cnt      (cnt),
    .wake     (wake_o)
);

// File: tb/sim_awu_timer.sv
`timescale 1ns/100ps
module sim_awu_timer;

    logic       clk = 1'b0;
    logic       lsi_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [5:0] wr_data = '0;
    logic       cfg_en_o;
    logic [3:0] cfg_psc_o;
    logic [5:0] cfg_win_o;
    logic       wake_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // shadow of the programmed registers, as the bench believes them
    int sh_en = 0, sh_psc = 0, sh_win = 63;

    // behavioural reference in the low-speed domain
    int q_en[$], q_psc[$], q_win[$];
    int m_mode = 0;      // 0 idle, 1 counting, 2 pulse
    int m_div_pos = 0, m_count = 0;
    bit exp_wake = 0;
    string phase_req = "R1";

    // observation
    int lsi_cnt = 0, rises = 0, first_rise = 0, last_rise = 0, interval = 0;
    int hi_run = 0, last_width = 0;
    bit prev_wake = 0;

    awu_timer u0 (
        .clk(clk), .rst_n(rst_n), .lsi_clk(lsi_clk),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_en_o(cfg_en_o), .cfg_psc_o(cfg_psc_o), .cfg_win_o(cfg_win_o),
        .wake_o(wake_o)
    );

    initial forever #2.5 clk = ~clk;
    initial begin
        #1 lsi_clk = 1'b1;
        forever #5 lsi_clk = ~lsi_clk;
    end

    function automatic int ratio_of(input int code);
        if (code <= 1) return 1;
        if (code == 14) return 10240;
        if (code == 15) return 61440;
        return 1 << (code - 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge lsi_clk) begin
        lsi_cnt++;
        if (!rst_n) begin
            q_en = '{0, 0}; q_psc = '{0, 0}; q_win = '{63, 63};
            m_mode = 0; m_div_pos = 0; m_count = 0; exp_wake = 0;
        end else begin
            int en2, psc2, win2, nmode;
            bit going, tk, match;
            en2 = q_en[0]; psc2 = q_psc[0]; win2 = q_win[0];
            going = (m_mode != 0) && (en2 == 1);
            tk    = going && (m_div_pos == ratio_of(psc2) - 1);
            match = tk && (m_count == win2);
            if (m_mode == 0)   nmode = (en2 == 1) ? 1 : 0;
            else if (en2 == 0) nmode = 0;
            else               nmode = match ? 2 : 1;
            if (!going) begin m_div_pos = 0; m_count = 0; end
            else begin
                m_div_pos = tk ? 0 : m_div_pos + 1;
                if (match)   m_count = 0;
                else if (tk) m_count = (m_count + 1) % 64;
            end
            m_mode = nmode;
            exp_wake = (m_mode == 2);
            void'(q_en.pop_front()); void'(q_psc.pop_front()); void'(q_win.pop_front());
            q_en.push_back(sh_en); q_psc.push_back(sh_psc); q_win.push_back(sh_win);
        end
    end

    always @(negedge lsi_clk) begin
        if (rst_n && !done) begin
            check(wake_o == exp_wake, phase_req, wake_o, exp_wake);
            if (wake_o && !prev_wake) begin
                if (rises == 0) first_rise = lsi_cnt;
                else interval = lsi_cnt - last_rise;
                last_rise = lsi_cnt;
                rises++;
            end
            if (wake_o) hi_run++;
            else begin
                if (hi_run > 0) last_width = hi_run;
                hi_run = 0;
            end
            prev_wake = wake_o;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [5:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_valid = 1'b0;
        if (a == 2'd0) sh_en  = d[0];
        if (a == 2'd1) sh_win = d;
        if (a == 2'd2) sh_psc = d[3:0];
    endtask

    task automatic start_run(input int psc, input int win, output int start);
        wr(2'd2, 6'(psc));
        wr(2'd1, 6'(win));
        rises = 0; last_width = 0;
        wr(2'd0, 6'd1);
        start = lsi_cnt;
    endtask

    task automatic stop_run();
        wr(2'd0, 6'd0);
        repeat (4) @(negedge lsi_clk);
    endtask

    task automatic wait_rises(input int n, input int lim, input string req);
        for (int i = 0; i < lim && rises < n; i++) @(negedge lsi_clk);
        check(rises >= n, req, rises, n);
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=0 exp=1");
        finish_run();
    end

    initial begin
        int st;
        #53 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset values
        check(cfg_en_o == 1'b0, "R1", cfg_en_o, 0);
        check(cfg_psc_o == 4'd0, "R1", cfg_psc_o, 0);
        check(cfg_win_o == 6'h3F, "R1", cfg_win_o, 63);
        check(wake_o == 1'b0, "R1", wake_o, 0);

        // R2 register port, unused address ignored
        phase_req = "R2";
        wr(2'd3, 6'h15);
        check(cfg_win_o == 6'h3F && cfg_psc_o == 4'd0 && cfg_en_o == 1'b0, "R2", cfg_win_o, 63);
        wr(2'd1, 6'd9);
        check(cfg_win_o == 6'd9, "R2", cfg_win_o, 9);
        wr(2'd2, 6'd5);
        check(cfg_psc_o == 4'd5, "R2", cfg_psc_o, 5);

        // R7 / R10 / R4: code 0, window 3
        phase_req = "R7";
        start_run(0, 3, st);
        check(cfg_en_o == 1'b1, "R2", cfg_en_o, 1);
        wait_rises(3, 100, "R7");
        check(first_rise == st + 3 + 4, "R10", first_rise, st + 7);
        check(interval == 4, "R7", interval, 4);
        check(last_width == 1, "R8", last_width, 1);
        stop_run();

        // R3 no wake while disabled
        phase_req = "R3";
        rises = 0;
        repeat (40) @(negedge lsi_clk);
        check(rises == 0, "R3", rises, 0);
        check(wake_o == 1'b0, "R3", wake_o, 0);

        // R4 code 1 same as code 0
        phase_req = "R4";
        start_run(1, 3, st);
        wait_rises(3, 100, "R4");
        check(interval == 4, "R4", interval, 4);
        check(first_rise == st + 7, "R4", first_rise, st + 7);
        stop_run();

        // R5 code 3 (ratio 4), window 2
        phase_req = "R5";
        start_run(3, 2, st);
        wait_rises(3, 200, "R5");
        check(interval == 12, "R5", interval, 12);
        check(last_width == 1, "R8", last_width, 1);
        stop_run();

        // R5 code 6 (ratio 32), window 5
        start_run(6, 5, st);
        wait_rises(3, 1000, "R5");
        check(interval == 192, "R5", interval, 192);
        check(first_rise == st + 3 + 192, "R5", first_rise, st + 195);
        stop_run();

        // R8 window 0, no division: continuous wake
        phase_req = "R8";
        start_run(0, 0, st);
        repeat (8) @(negedge lsi_clk);
        for (int i = 0; i < 4; i++) begin
            check(wake_o == 1'b1, "R8", wake_o, 1);
            @(negedge lsi_clk);
        end
        stop_run();

        // R9 disable mid-count restarts the full period
        phase_req = "R9";
        start_run(0, 7, st);
        repeat (3) @(negedge lsi_clk);
        wr(2'd0, 6'd0);
        repeat (6) @(negedge lsi_clk);
        check(rises == 0, "R9", rises, 0);
        rises = 0;
        wr(2'd0, 6'd1);
        st = lsi_cnt;
        wait_rises(1, 100, "R9");
        check(first_rise == st + 3 + 8, "R9", first_rise, st + 11);
        stop_run();

        // R6 long ratios
        phase_req = "R6";
        start_run(14, 0, st);
        wait_rises(1, 10400, "R6");
        check(first_rise == st + 3 + 10240, "R6", first_rise, st + 10243);
        stop_run();

        start_run(15, 0, st);
        wait_rises(1, 61600, "R6");
        check(first_rise == st + 3 + 61440, "R6", first_rise, st + 61443);
        stop_run();

        finish_run();
    end

endmodule